// File: doc/BRIEF.md
# Byte-Serial Counter Register Interface

This block is the host-facing register file for a single quadrature counter channel. The host reaches it through two 8-bit ports. The data port moves the 24-bit preset in and the 24-bit output latch out, one byte per access. The control port takes command bytes, and its top three bits pick the target. One command group performs resets and transfers. The other three groups load the counting-mode register, the input/output control register and the index control register. A read of the control port returns the live status flags of the counter core.

A small state machine acts as the byte pointer. Its states are `PTR_B0`, `PTR_B1` and `PTR_B2`. On each data-port access it steps `PTR_B0 -> PTR_B1 -> PTR_B2 -> PTR_B0`. A pointer-restart command sends it from any state straight to `PTR_B0`. One command byte can carry several actions at once. For example, 0x11 restarts the pointer and also captures the counter into the output latch, so a following three-byte read returns a coherent snapshot.

Each access is a single-cycle strobe with a port select. Register updates and the one-cycle core strobes appear one cycle after the access. Read data is combinational in the cycle of the read strobe.

Top module: `qc_host_regs`

## Requirements
- R1: After reset the preset, output latch and all configuration outputs are zero, all strobes are low, and the pointer is in `PTR_B0`.
- R2: Successive data-port writes load preset bytes 0, 1 and 2 in that order, least significant byte first. A reset/load command (bits 7:5 = 000) with bit 0 set returns the pointer to byte 0.
- R3: A data-port access made while the pointer is on byte 2 moves it back to byte 0, so a fourth write lands in byte 0 again.
- R4: A reset/load command with bit 4 set copies `core_count` into the output latch. Successive data-port reads return latch bytes 0, 1 and 2, least significant byte first. The latch is unchanged otherwise.
- R5: A reset/load command with bit 3 set raises `load_preset` for exactly the one cycle after the command.
- R6: In a reset/load command, bits 2:1 = 11 (for example 0x06) pulse `clear_noise` for one cycle, and bits 2:1 = 01 (for example 0x02) pulse `clear_flags` for one cycle. Other values pulse neither.
- R7: A command with bits 7:5 = 001 sets `count_mode` from bits 2:1 (0 normal, 1 range limit, 2 non-recycle, 3 modulo-N) and `quad_sel` from bits 4:3 (0 non-quadrature, 1 x1, 2 x2, 3 x4).
- R8: A command with bits 7:5 = 010 sets `ab_enable` from bit 0 and `index_preset_en` from bit 1.
- R9: A command with bits 7:5 = 011 sets `index_sync` from bit 0 and `index_pos_pol` from bit 1. If bit 0 is 1 while `quad_sel` is 0, the whole command is ignored and both fields keep their values.
- R10: A control-port read returns, in the same cycle, bit 0 borrow, bit 1 carry, bit 4 noise error, bit 5 count direction (1 = up), and zeros elsewhere. `host_rdata` is zero in any cycle without a read.
- R11: Commands with bits 7:5 in 100..111 change no register, no strobe and not the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Single-cycle write strobe |
| host_rd | input | 1 | Single-cycle read strobe |
| host_ctrl_sel | input | 1 | 1 selects the control port, 0 the data port |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid in the cycle of `host_rd` |
| core_count | input | 24 | Current counter value from the core |
| core_borrow | input | 1 | Borrow flag from the core |
| core_carry | input | 1 | Carry flag from the core |
| core_noise | input | 1 | Noise error flag from the core |
| core_up | input | 1 | Count direction from the core, 1 = up |
| preset_val | output | 24 | Preset register |
| load_preset | output | 1 | Pulse: transfer preset into counter |
| clear_flags | output | 1 | Pulse: clear borrow, carry, compare and sign |
| clear_noise | output | 1 | Pulse: clear noise error flag |
| count_mode | output | 2 | Counting mode |
| quad_sel | output | 2 | Quadrature select |
| ab_enable | output | 1 | Enable A/B inputs |
| index_preset_en | output | 1 | Preset on index enable |
| index_sync | output | 1 | Synchronous index mode |
| index_pos_pol | output | 1 | Positive index polarity |

## Verification
The hardest case to reach is the refused synchronous-index request. It needs `quad_sel` at zero together with an index command that has bit 0 set. Random traffic mostly leaves quadrature enabled once a mode write has occurred. The stimulus therefore includes directed sequences that first set the index fields under quadrature, then clear `quad_sel`, then send a synchronous request with a different polarity. Random traffic also draws mode bytes with a bias toward a zero quadrature field. Pointer wrap is reached by mixing data reads and writes across the byte-2 boundary, with no restart command between them.

// File: rtl/qc_pkg.sv
package qc_pkg;
    localparam int PORT_W     = 8;
    localparam int COUNT_BYTES = 3;
    localparam int COUNT_W    = PORT_W * COUNT_BYTES;

    typedef enum logic [1:0] {
        PTR_B0 = 2'd0,
        PTR_B1 = 2'd1,
        PTR_B2 = 2'd2
    } ptr_state_e;

    typedef enum logic [2:0] {
        CLS_RESET = 3'b000,
        CLS_MODE  = 3'b001,
        CLS_IOCTL = 3'b010,
        CLS_INDEX = 3'b011
    } cmd_class_e;

    typedef struct packed {
        logic ptr_restart;
        logic xfer_preset;
        logic xfer_latch;
        logic clr_flags;
        logic clr_noise;
        logic ld_mode;
        logic ld_ioctl;
        logic ld_index;
    } cmd_t;
endpackage

// File: rtl/qc_byte_ptr.sv
module qc_byte_ptr
    import qc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       advance,
    input  logic       restart,
    output ptr_state_e state,
    output logic [1:0] byte_idx
);
    ptr_state_e next_state;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PTR_B0;
        else        state <= next_state;
    end

    always_comb begin
        next_state = state;
        if (restart) begin
            next_state = PTR_B0;
        end else if (advance) begin
            unique case (state)
                PTR_B0:  next_state = PTR_B1;
                PTR_B1:  next_state = PTR_B2;
                PTR_B2:  next_state = PTR_B0;
                default: next_state = PTR_B0;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            PTR_B0:  byte_idx = 2'd0;
            PTR_B1:  byte_idx = 2'd1;
            PTR_B2:  byte_idx = 2'd2;
            default: byte_idx = 2'd0;
        endcase
    end

    // R3: stepping past byte 2 lands on byte 0
    a_r3_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !restart && state == PTR_B2) |=> state == PTR_B0);
    // R2: restart command always returns to byte 0
    a_r2_ptr_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> state == PTR_B0);
endmodule

// File: rtl/qc_cmd_decode.sv
module qc_cmd_decode
    import qc_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         valid,
    input  logic [W-1:0] cmd,
    output cmd_t         dec
);
    logic [2:0] cls;
    logic       is_reset;

    assign cls      = cmd[W-1 -: 3];
    assign is_reset = valid && (cls == CLS_RESET);

    always_comb begin
        dec             = '0;
        dec.ptr_restart = is_reset && cmd[0];
        dec.xfer_preset = is_reset && cmd[3];
        dec.xfer_latch  = is_reset && cmd[4];
        dec.clr_flags   = is_reset && (cmd[2:1] == 2'b01);
        dec.clr_noise   = is_reset && (cmd[2:1] == 2'b11);
        dec.ld_mode     = valid && (cls == CLS_MODE);
        dec.ld_ioctl    = valid && (cls == CLS_IOCTL);
        dec.ld_index    = valid && (cls == CLS_INDEX);
    end
endmodule

// File: rtl/qc_cfg_regs.sv
module qc_cfg_regs
    import qc_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cmd_t         dec,
    input  logic         upper_cls,
    input  logic [W-1:0] wdata,
    output logic         load_preset,
    output logic         clear_flags,
    output logic         clear_noise,
    output logic [1:0]   count_mode,
    output logic [1:0]   quad_sel,
    output logic         ab_enable,
    output logic         index_preset_en,
    output logic         index_sync,
    output logic         index_pos_pol
);
    logic sync_refused;
    assign sync_refused = wdata[0] && (quad_sel == 2'd0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_preset     <= 1'b0;
            clear_flags     <= 1'b0;
            clear_noise     <= 1'b0;
            count_mode      <= 2'd0;
            quad_sel        <= 2'd0;
            ab_enable       <= 1'b0;
            index_preset_en <= 1'b0;
            index_sync      <= 1'b0;
            index_pos_pol   <= 1'b0;
        end else begin
            load_preset <= dec.xfer_preset;
            clear_flags <= dec.clr_flags;
            clear_noise <= dec.clr_noise;
            if (dec.ld_mode) begin
                count_mode <= wdata[2:1];
                quad_sel   <= wdata[4:3];
            end
            if (dec.ld_ioctl) begin
                ab_enable       <= wdata[0];
                index_preset_en <= wdata[1];
            end
            if (dec.ld_index && !sync_refused) begin
                index_sync    <= wdata[0];
                index_pos_pol <= wdata[1];
            end
        end
    end

    // R9: synchronous request without quadrature leaves index fields alone
    a_r9_sync_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.ld_index && wdata[0] && quad_sel == 2'd0)
        |=> ($stable(index_sync) && $stable(index_pos_pol)));
    // R5: load pulse only follows a transfer command
    a_r5_load_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_preset) |-> $past(dec.xfer_preset));
    // R6: the two clear pulses never come from one command
    a_r6_clear_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clear_flags, clear_noise}));
    // R11: upper command classes leave the configuration untouched
    a_r11_upper_inert: assert property (@(posedge clk) disable iff (!rst_n)
        upper_cls |=> ($stable(count_mode) && $stable(quad_sel) &&
                       $stable(ab_enable) && $stable(index_preset_en) &&
                       $stable(index_sync) && $stable(index_pos_pol)));
endmodule

// File: rtl/qc_host_regs.sv
module qc_host_regs
    import qc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic               host_ctrl_sel,
    input  logic [PORT_W-1:0]  host_wdata,
    output logic [PORT_W-1:0]  host_rdata,
    input  logic [COUNT_W-1:0] core_count,
    input  logic               core_borrow,
    input  logic               core_carry,
    input  logic               core_noise,
    input  logic               core_up,
    output logic [COUNT_W-1:0] preset_val,
    output logic               load_preset,
    output logic               clear_flags,
    output logic               clear_noise,
    output logic [1:0]         count_mode,
    output logic [1:0]         quad_sel,
    output logic               ab_enable,
    output logic               index_preset_en,
    output logic               index_sync,
    output logic               index_pos_pol
);
    logic               ctrl_wr;
    logic               data_wr;
    logic               data_rd;
    logic               upper_cls;
    cmd_t               dec;
    ptr_state_e         ptr_state;
    logic [1:0]         byte_idx;
    logic [COUNT_W-1:0] out_latch;
    logic [PORT_W-1:0]  status_byte;
    logic [PORT_W-1:0]  latch_byte;

    assign ctrl_wr   = host_wr && host_ctrl_sel;
    assign data_wr   = host_wr && !host_ctrl_sel;
    assign data_rd   = host_rd && !host_ctrl_sel;
    assign upper_cls = ctrl_wr && host_wdata[PORT_W-1];

    qc_cmd_decode #(.W(PORT_W)) u_dec (
        .valid (ctrl_wr),
        .cmd   (host_wdata),
        .dec   (dec)
    );

    qc_byte_ptr u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (data_wr || data_rd),
        .restart  (dec.ptr_restart),
        .state    (ptr_state),
        .byte_idx (byte_idx)
    );

    qc_cfg_regs #(.W(PORT_W)) u_cfg (
        .clk             (clk),
        .rst_n           (rst_n),
        .dec             (dec),
        .upper_cls       (upper_cls),
        .wdata           (host_wdata),
        .load_preset     (load_preset),
        .clear_flags     (clear_flags),
        .clear_noise     (clear_noise),
        .count_mode      (count_mode),
        .quad_sel        (quad_sel),
        .ab_enable       (ab_enable),
        .index_preset_en (index_preset_en),
        .index_sync      (index_sync),
        .index_pos_pol   (index_pos_pol)
    );

    for (genvar b = 0; b < COUNT_BYTES; b++) begin : g_preset
        always_ff @(posedge clk) begin
            if (!rst_n)
                preset_val[b*PORT_W +: PORT_W] <= '0;
            else if (data_wr && byte_idx == b[1:0])
                preset_val[b*PORT_W +: PORT_W] <= host_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)               out_latch <= '0;
        else if (dec.xfer_latch)  out_latch <= core_count;
    end

    always_comb begin
        status_byte    = '0;
        status_byte[0] = core_borrow;
        status_byte[1] = core_carry;
        status_byte[4] = core_noise;
        status_byte[5] = core_up;
    end

    always_comb begin
        unique case (ptr_state)
            PTR_B0:  latch_byte = out_latch[0*PORT_W +: PORT_W];
            PTR_B1:  latch_byte = out_latch[1*PORT_W +: PORT_W];
            PTR_B2:  latch_byte = out_latch[2*PORT_W +: PORT_W];
            default: latch_byte = '0;
        endcase
    end

    always_comb begin
        if (!host_rd)           host_rdata = '0;
        else if (host_ctrl_sel) host_rdata = status_byte;
        else                    host_rdata = latch_byte;
    end

    // R10: the read bus is quiet between reads
    a_r10_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |-> host_rdata == '0);
    // R4: the latch moves only on a capture command
    a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dec.xfer_latch |=> $stable(out_latch));
    // R11: upper classes do not move the pointer
    a_r11_ptr_still: assert property (@(posedge clk) disable iff (!rst_n)
        (upper_cls && !host_rd) |=> $stable(ptr_state));
endmodule

// File: tb/qc_host_regs_bench.sv
module qc_host_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_wr, host_rd, host_ctrl_sel;
    logic [7:0]  host_wdata, host_rdata;
    logic [23:0] core_count;
    logic        core_borrow, core_carry, core_noise, core_up;
    logic [23:0] preset_val;
    logic        load_preset, clear_flags, clear_noise;
    logic [1:0]  count_mode, quad_sel;
    logic        ab_enable, index_preset_en, index_sync, index_pos_pol;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // model state
    logic [23:0] m_preset, m_latch;
    int          m_ptr;
    logic [1:0]  m_mode, m_quad;
    logic        m_ab, m_pie, m_sync, m_pol;
    logic        m_ld, m_cf, m_cn;

    always #2 clk = ~clk;

    qc_host_regs u_qc_host_regs (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_ctrl_sel(host_ctrl_sel), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .core_count(core_count),
        .core_borrow(core_borrow), .core_carry(core_carry),
        .core_noise(core_noise), .core_up(core_up),
        .preset_val(preset_val), .load_preset(load_preset),
        .clear_flags(clear_flags), .clear_noise(clear_noise),
        .count_mode(count_mode), .quad_sel(quad_sel),
        .ab_enable(ab_enable), .index_preset_en(index_preset_en),
        .index_sync(index_sync), .index_pos_pol(index_pos_pol)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status(logic b, logic c, logic n, logic u);
        return {2'b00, u, n, 2'b00, c, b};
    endfunction

    task automatic check_all(string req);
        check({req, " preset"}, {8'h0, preset_val}, {8'h0, m_preset});
        check({req, " mode"}, {count_mode, quad_sel}, {m_mode, m_quad});
        check({req, " ioctl"}, {ab_enable, index_preset_en}, {m_ab, m_pie});
        check({req, " index"}, {index_sync, index_pos_pol}, {m_sync, m_pol});
        check({req, " strobes"}, {load_preset, clear_flags, clear_noise},
              {m_ld, m_cf, m_cn});
    endtask

    // one host access; model updated in step with the design
    task automatic op(bit wr, bit rd, bit sel, logic [7:0] d, string req);
        logic [7:0] exp_rd;
        @(negedge clk);
        core_count  = 24'($urandom);
        core_borrow = 1'($urandom); core_carry = 1'($urandom);
        core_noise  = 1'($urandom); core_up    = 1'($urandom);
        host_wr = wr; host_rd = rd; host_ctrl_sel = sel; host_wdata = d;
        #1;
        if (rd) begin
            exp_rd = sel ? exp_status(core_borrow, core_carry, core_noise, core_up)
                         : m_latch[m_ptr*8 +: 8];
            check({req, " rdata"}, {24'h0, host_rdata}, {24'h0, exp_rd});
        end
        m_ld = 0; m_cf = 0; m_cn = 0;
        if (wr && !sel) m_preset[m_ptr*8 +: 8] = d;
        if (wr && sel) begin
            case (d[7:5])
                3'b000: begin
                    if (d[4]) m_latch = core_count;
                    m_ld = d[3];
                    m_cf = (d[2:1] == 2'b01);
                    m_cn = (d[2:1] == 2'b11);
                end
                3'b001: begin m_mode = d[2:1]; m_quad = d[4:3]; end
                3'b010: begin m_ab = d[0]; m_pie = d[1]; end
                3'b011: if (!(d[0] && m_quad == 0)) begin
                            m_sync = d[0]; m_pol = d[1];
                        end
                default: ;
            endcase
        end
        if (wr && sel && d[7:5] == 3'b000 && d[0]) m_ptr = 0;
        else if (!sel && (wr || rd)) m_ptr = (m_ptr == 2) ? 0 : m_ptr + 1;
        @(negedge clk);
        host_wr = 0; host_rd = 0;
        check_all(req);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        host_wr = 0; host_rd = 0; host_ctrl_sel = 0; host_wdata = 0;
        core_count = 0; core_borrow = 0; core_carry = 0; core_noise = 0; core_up = 0;
        m_preset = 0; m_latch = 0; m_ptr = 0; m_mode = 0; m_quad = 0;
        m_ab = 0; m_pie = 0; m_sync = 0; m_pol = 0; m_ld = 0; m_cf = 0; m_cn = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1 reset");
        op(0, 1, 0, 8'h00, "R1 latch zero");
        op(1, 0, 1, 8'h01, "R2 restart");
        // R2: LSB-first preset fill
        op(1, 0, 0, 8'h11, "R2 byte0");
        op(1, 0, 0, 8'h22, "R2 byte1");
        op(1, 0, 0, 8'h33, "R2 byte2");
        check("R2 preset value", {8'h0, preset_val}, 32'h00332211);
        // R3: fourth write wraps to byte 0
        op(1, 0, 0, 8'hAA, "R3 wrap");
        check("R3 wrap value", {8'h0, preset_val}, 32'h003322AA);
        // R5 preset transfer, R6 clear codes
        op(1, 0, 1, 8'h08, "R5 load pulse");
        op(0, 0, 1, 8'h00, "R5 pulse ends");
        op(1, 0, 1, 8'h06, "R6 clear noise");
        op(1, 0, 1, 8'h02, "R6 clear flags");
        // R4: packed restart + capture then three reads
        op(1, 0, 1, 8'h11, "R4 capture");
        op(0, 1, 0, 8'h00, "R4 read0");
        op(0, 1, 0, 8'h00, "R4 read1");
        op(0, 1, 0, 8'h00, "R4 read2");
        op(0, 1, 0, 8'h00, "R4 read wrap");
        // R7, R8
        op(1, 0, 1, 8'h3E, "R7 modulo-N x4");
        op(1, 0, 1, 8'h43, "R8 ioctl");
        // R9 guard
        op(1, 0, 1, 8'h61, "R9 sync with quad");
        op(1, 0, 1, 8'h20, "R7 non-quad");
        op(1, 0, 1, 8'h63, "R9 refused sync");
        check("R9 refused kept", {30'h0, index_sync, index_pos_pol}, 32'h2);
        op(1, 0, 1, 8'h62, "R9 non-sync accepted");
        // R10 status, R11 upper classes
        op(0, 1, 1, 8'h00, "R10 status");
        op(1, 0, 1, 8'hFF, "R11 upper class");
        op(1, 0, 1, 8'h9B, "R11 upper class");
        op(0, 1, 0, 8'h00, "R11 ptr unchanged");
        // random mix
        for (int i = 0; i < 600; i++) begin
            int k;
            logic [7:0] d;
            k = int'($urandom_range(0, 8));
            d = 8'($urandom);
            case (k)
                0: op(1, 0, 0, d, "R2 rnd data wr");
                1: op(0, 1, 0, d, "R4 rnd data rd");
                2: op(1, 0, 1, {3'b000, d[4:0]}, "R6 rnd reset cmd");
                3: op(1, 0, 1, {3'b001, (d[7] ? 2'b00 : d[4:3]), d[2:0]}, "R7 rnd mode");
                4: op(1, 0, 1, {3'b010, d[4:0]}, "R8 rnd ioctl");
                5: op(1, 0, 1, {3'b011, d[4:0]}, "R9 rnd index");
                6: op(0, 1, 1, d, "R10 rnd status");
                7: op(1, 0, 1, {1'b1, d[6:0]}, "R11 rnd upper");
                default: op(0, 1, 0, d, "R3 rnd read");
            endcase
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule